// File: doc/BRIEF.md
# DMA Channel Bus Request Generator

This block decides when one DMA channel asks the master-interface arbiter for the bus. It holds two copies of the same state machine, one for the source side of the channel and one for the destination side. The two copies run at the same time, and each drives its own request line to the arbiter. A side that serves a handshaking peripheral waits for a single or burst request from that peripheral. A side that serves memory needs no handshake. Either kind of side asks for the bus only once the channel FIFO, as judged by an external readiness evaluator, can serve a beat for that side.

A beat is issued in the cycle in which a side is requesting, the arbiter grants it, and the master interface holds the external bus. The side then waits for the bus response, which counts only when the ready signal is high. A RETRY or SPLIT response makes the side request again and reissue the same transfer. This repeats until the response is OKAY. An ERROR response parks the side in a sticky error state.

When the destination is the flow controller and prefetching is switched off, the source side holds back its request until the destination peripheral has asked for new data. That permission is used up by one completed source beat.

Top module: `dma_bus_req_gen`

## Requirements
- R1: Source and destination each drive their own arbiter request, and both can be high in the same cycle. A raised request stays high until the cycle in which its arbiter grant and the external bus grant are both high.
- R2: The transfer strobe of a side is high in exactly the cycle in which that side requests and both grants are high. In the next cycle the request is low.
- R3: A non-memory side, with the channel enabled, raises its request one clock after a clock edge at which a single or burst peripheral request and FIFO readiness are both high.
- R4: A non-memory side never requests the bus while it has no peripheral request, even if the FIFO is ready.
- R5: A memory side ignores peripheral requests and raises its request one clock after an edge at which the FIFO is ready.
- R6: While the FIFO is not ready for a side, that side does not request. It requests one clock after readiness returns.
- R7: When destination-is-flow-controller and prefetch-off are both 1, the source does not request until a destination single or burst request has been seen. That permission stays latched and is consumed by the source's next OKAY completion.
- R8: Response encoding is OKAY=2'b00, ERROR=2'b01, RETRY=2'b10, SPLIT=2'b11. After a RETRY or SPLIT, the side raises its request together with the reissue flag in the next cycle, whatever the FIFO readiness. This repeats until an OKAY arrives, which clears the reissue flag.
- R9: After an ERROR, the error flag is set and stays set, with no further request from that side, until the channel enable goes low. The flag then clears.
- R10: A response is taken only when the ready signal is high. While ready is low, the side neither requests nor strobes.
- R11: After reset, all requests, strobes, reissue flags and error flags are low.
- R12: With the channel enable low, neither side requests, whatever the peripheral requests and FIFO readiness are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | 1 | Channel enable |
| src_single_req | input | 1 | Source peripheral single request |
| src_burst_req | input | 1 | Source peripheral burst request |
| src_is_mem | input | 1 | Source is memory (no handshake) |
| src_fifo_rdy | input | 1 | FIFO ready for a source beat |
| src_arb_gnt | input | 1 | Arbiter grant to source side |
| dst_single_req | input | 1 | Destination peripheral single request |
| dst_burst_req | input | 1 | Destination peripheral burst request |
| dst_is_mem | input | 1 | Destination is memory (no handshake) |
| dst_fifo_rdy | input | 1 | FIFO ready for a destination beat |
| dst_arb_gnt | input | 1 | Arbiter grant to destination side |
| dst_is_flowctl | input | 1 | Destination is the flow controller |
| prefetch_off | input | 1 | Source prefetching disabled |
| bus_gnt | input | 1 | Master interface holds the external bus |
| hready | input | 1 | Bus response valid |
| hresp | input | 2 | Bus response code |
| src_arb_req | output | 1 | Source request to arbiter |
| dst_arb_req | output | 1 | Destination request to arbiter |
| src_xfer_strb | output | 1 | Source beat issued |
| dst_xfer_strb | output | 1 | Destination beat issued |
| src_reissue | output | 1 | Source is reissuing a retried transfer |
| dst_reissue | output | 1 | Destination is reissuing a retried transfer |
| src_err | output | 1 | Source sticky error |
| dst_err | output | 1 | Destination sticky error |

## Verification
The embedded assertions check, on every cycle, that a request is held until it is granted and then dropped, and that a RETRY or SPLIT is always followed by a reissue request. They also check that the error flag stays set while the channel is enabled, that nothing is requested during a wait state, and that a source request rises only when the prefetch hold allowed it. Only the directed scenarios can show the rest. These are the exact latency from a peripheral request or from FIFO readiness to the bus request, and the fact that memory sides ignore handshakes. They also cover the absence of any request when there is no peripheral request or the channel is disabled, and the one-beat lifetime of the destination's permission.

// File: rtl/dma_req_pkg.sv
// Shared types for the DMA channel bus request generator.
// Assumes a two-bit bus response and exactly two sides per channel.
package dma_req_pkg;
    localparam int RESP_W    = 2;
    localparam int NUM_SIDES = 2;
    localparam int SIDE_SRC  = 0;
    localparam int SIDE_DST  = 1;

    typedef enum logic [RESP_W-1:0] {
        RSP_OKAY  = 2'b00,
        RSP_ERROR = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SPLIT = 2'b11
    } bus_resp_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_WAIT_READY,
        ST_REQ_BUS,
        ST_XFER,
        ST_REISSUE,
        ST_ERR
    } side_state_e;
endpackage

// File: rtl/dma_side_fsm.sv
// One side (source or destination) of a DMA channel request generator.
// It waits for a peripheral request (unless the side is memory), then for FIFO
// readiness and an external permission, then requests the arbiter. It issues a
// beat on a double grant, and it retries after RETRY/SPLIT until OKAY.
// Assumes the arbiter never grants both sides in the same cycle.
module dma_side_fsm
    import dma_req_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_en_i,
    input  logic              single_req_i,
    input  logic              burst_req_i,
    input  logic              is_mem_i,
    input  logic              fifo_rdy_i,
    input  logic              allow_i,
    input  logic              arb_gnt_i,
    input  logic              bus_gnt_i,
    input  logic              hready_i,
    input  logic [RESP_W-1:0] hresp_i,
    output logic              arb_req_o,
    output logic              xfer_strb_o,
    output logic              reissue_o,
    output logic              err_o,
    output logic              done_o
);
    side_state_e st_q, st_d;
    logic        both_gnt;
    logic        has_trigger;
    logic        can_go;
    bus_resp_e   rsp;

    assign both_gnt    = arb_gnt_i && bus_gnt_i;
    assign has_trigger = is_mem_i || single_req_i || burst_req_i;
    assign can_go      = fifo_rdy_i && allow_i;
    assign rsp         = bus_resp_e'(hresp_i);

    // Next-state selection for the side.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ch_en_i) st_d = ST_WAIT_REQ;
            end
            ST_WAIT_REQ: begin
                if (!ch_en_i)         st_d = ST_IDLE;
                else if (has_trigger) st_d = can_go ? ST_REQ_BUS : ST_WAIT_READY;
            end
            ST_WAIT_READY: begin
                if (!ch_en_i)    st_d = ST_IDLE;
                else if (can_go) st_d = ST_REQ_BUS;
            end
            ST_REQ_BUS: begin
                if (both_gnt) st_d = ST_XFER;
            end
            ST_XFER: begin
                if (hready_i) begin
                    unique case (rsp)
                        RSP_OKAY:  st_d = ch_en_i ? ST_WAIT_REQ : ST_IDLE;
                        RSP_ERROR: st_d = ST_ERR;
                        RSP_RETRY,
                        RSP_SPLIT: st_d = ST_REISSUE;
                        default:   st_d = ST_ERR;
                    endcase
                end
            end
            ST_REISSUE: begin
                if (both_gnt) st_d = ST_XFER;
            end
            ST_ERR: begin
                if (!ch_en_i) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Output decode.
    always_comb begin
        arb_req_o   = (st_q == ST_REQ_BUS) || (st_q == ST_REISSUE);
        xfer_strb_o = arb_req_o && both_gnt;
        reissue_o   = (st_q == ST_REISSUE);
        err_o       = (st_q == ST_ERR);
        done_o      = (st_q == ST_XFER) && hready_i && (rsp == RSP_OKAY);
    end

    // R1: a request is held until both grants arrive.
    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arb_req_o && !both_gnt |=> arb_req_o);

    // R2: after a strobe the request is released.
    p_strb_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_strb_o |=> !arb_req_o);

    // R8: RETRY/SPLIT leads to a reissue request in the next cycle.
    p_reissue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XFER) && hready_i && hresp_i[1] |=> reissue_o && arb_req_o);

    // R9: the error flag holds while the channel stays enabled.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o && ch_en_i |=> err_o && !arb_req_o);

    // R10: a wait state keeps the side quiet.
    p_wait_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_XFER) && !hready_i |=> !arb_req_o && !xfer_strb_o);
endmodule

// File: rtl/dma_prefetch_gate.sv
// Source hold-off used when prefetching is disabled and the destination is the
// flow controller. A destination data request latches a permission, and the
// source's next OKAY completion consumes it. Assumes src_done_i is a one-cycle pulse.
module dma_prefetch_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ch_en_i,
    input  logic hold_mode_i,
    input  logic dst_want_i,
    input  logic src_done_i,
    output logic src_allow_o
);
    logic want_q;

    // Permission latch: set by a destination request, cleared by a source beat.
    always_ff @(posedge clk) begin
        if (!rst_n || !ch_en_i) want_q <= 1'b0;
        else if (dst_want_i)    want_q <= 1'b1;
        else if (src_done_i)    want_q <= 1'b0;
    end

    // Source may proceed when the hold is off or a permission is pending.
    assign src_allow_o = !hold_mode_i || want_q;

    // R7: a consumed permission is gone unless renewed in the same cycle.
    p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        src_done_i && !dst_want_i && hold_mode_i && ch_en_i |=> !src_allow_o);
endmodule

// File: rtl/dma_bus_req_gen.sv
// Channel bus request generator: two side state machines plus the source
// hold-off gate. Assumes the arbiter grants at most one side per cycle.
module dma_bus_req_gen
    import dma_req_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_en,
    input  logic              src_single_req,
    input  logic              src_burst_req,
    input  logic              src_is_mem,
    input  logic              src_fifo_rdy,
    input  logic              src_arb_gnt,
    input  logic              dst_single_req,
    input  logic              dst_burst_req,
    input  logic              dst_is_mem,
    input  logic              dst_fifo_rdy,
    input  logic              dst_arb_gnt,
    input  logic              dst_is_flowctl,
    input  logic              prefetch_off,
    input  logic              bus_gnt,
    input  logic              hready,
    input  logic [RESP_W-1:0] hresp,
    output logic              src_arb_req,
    output logic              dst_arb_req,
    output logic              src_xfer_strb,
    output logic              dst_xfer_strb,
    output logic              src_reissue,
    output logic              dst_reissue,
    output logic              src_err,
    output logic              dst_err
);
    logic [NUM_SIDES-1:0] v_single, v_burst, v_mem, v_rdy, v_gnt, v_allow;
    logic [NUM_SIDES-1:0] v_req, v_strb, v_reis, v_err, v_done;
    logic                 src_allow;

    // Pack per-side inputs by side index.
    assign v_single = {dst_single_req, src_single_req};
    assign v_burst  = {dst_burst_req,  src_burst_req};
    assign v_mem    = {dst_is_mem,     src_is_mem};
    assign v_rdy    = {dst_fifo_rdy,   src_fifo_rdy};
    assign v_gnt    = {dst_arb_gnt,    src_arb_gnt};
    assign v_allow  = {1'b1,           src_allow};

    dma_prefetch_gate i_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_en_i     (ch_en),
        .hold_mode_i (dst_is_flowctl && prefetch_off),
        .dst_want_i  (dst_single_req || dst_burst_req),
        .src_done_i  (v_done[SIDE_SRC]),
        .src_allow_o (src_allow)
    );

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        dma_side_fsm i_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .ch_en_i      (ch_en),
            .single_req_i (v_single[g]),
            .burst_req_i  (v_burst[g]),
            .is_mem_i     (v_mem[g]),
            .fifo_rdy_i   (v_rdy[g]),
            .allow_i      (v_allow[g]),
            .arb_gnt_i    (v_gnt[g]),
            .bus_gnt_i    (bus_gnt),
            .hready_i     (hready),
            .hresp_i      (hresp),
            .arb_req_o    (v_req[g]),
            .xfer_strb_o  (v_strb[g]),
            .reissue_o    (v_reis[g]),
            .err_o        (v_err[g]),
            .done_o       (v_done[g])
        );
    end

    // Unpack per-side outputs.
    assign src_arb_req   = v_req[SIDE_SRC];
    assign dst_arb_req   = v_req[SIDE_DST];
    assign src_xfer_strb = v_strb[SIDE_SRC];
    assign dst_xfer_strb = v_strb[SIDE_DST];
    assign src_reissue   = v_reis[SIDE_SRC];
    assign dst_reissue   = v_reis[SIDE_DST];
    assign src_err       = v_err[SIDE_SRC];
    assign dst_err       = v_err[SIDE_DST];

    // R7: a fresh source request needs the gate's permission one cycle earlier.
    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_arb_req) && !src_reissue |-> $past(src_allow));

    // R2: at most one beat is issued per cycle.
    p_one_strb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(v_strb));
endmodule

// File: tb/test_dma_bus_req_gen.sv
module test_dma_bus_req_gen;
    logic clk = 1'b0;
    logic rst_n;
    logic ch_en, src_single_req, src_burst_req, src_is_mem, src_fifo_rdy, src_arb_gnt;
    logic dst_single_req, dst_burst_req, dst_is_mem, dst_fifo_rdy, dst_arb_gnt;
    logic dst_is_flowctl, prefetch_off, bus_gnt, hready;
    logic [1:0] hresp;
    logic src_arb_req, dst_arb_req, src_xfer_strb, dst_xfer_strb;
    logic src_reissue, dst_reissue, src_err, dst_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    dma_bus_req_gen i_dma_bus_req_gen (.*);

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_all();
        ch_en = 0; src_single_req = 0; src_burst_req = 0; src_is_mem = 0;
        src_fifo_rdy = 0; src_arb_gnt = 0; dst_single_req = 0; dst_burst_req = 0;
        dst_is_mem = 0; dst_fifo_rdy = 0; dst_arb_gnt = 0; dst_is_flowctl = 0;
        prefetch_off = 0; bus_gnt = 0; hready = 0; hresp = 2'b00;
        tick(); tick();
    endtask

    task automatic t_reset();
        chk("R11 src_arb_req", src_arb_req, 0);
        chk("R11 dst_arb_req", dst_arb_req, 0);
        chk("R11 strobes", src_xfer_strb | dst_xfer_strb, 0);
        chk("R11 reissue", src_reissue | dst_reissue, 0);
        chk("R11 err", src_err | dst_err, 0);
    endtask

    task automatic t_disabled();
        src_single_req = 1; dst_burst_req = 1; src_fifo_rdy = 1; dst_fifo_rdy = 1;
        src_is_mem = 1; dst_is_mem = 1;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R12 src no req", src_arb_req, 0);
            chk("R12 dst no req", dst_arb_req, 0);
        end
        idle_all();
    endtask

    task automatic t_handshake();
        ch_en = 1; src_fifo_rdy = 1; dst_fifo_rdy = 1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4 src idle w/o periph req", src_arb_req, 0);
            chk("R4 dst idle w/o periph req", dst_arb_req, 0);
        end
        src_single_req = 1; dst_burst_req = 1;
        tick();
        chk("R3 src req after single", src_arb_req, 1);
        chk("R1 dst req concurrently", dst_arb_req, 1);
        src_single_req = 0; dst_burst_req = 0;
        src_arb_gnt = 1;
        #1 chk("R2 no strobe without bus grant", src_xfer_strb, 0);
        for (int i = 0; i < 2; i++) begin
            tick();
            chk("R1 src req held", src_arb_req, 1);
        end
        bus_gnt = 1;
        #1 chk("R2 src strobe on double grant", src_xfer_strb, 1);
        chk("R2 dst no strobe", dst_xfer_strb, 0);
        tick();
        src_arb_gnt = 0; bus_gnt = 0;
        #1 chk("R2 src req dropped", src_arb_req, 0);
        chk("R1 dst still held", dst_arb_req, 1);
        tick();
        chk("R10 no req in wait state", src_arb_req, 0);
        hready = 1; hresp = 2'b00;
        tick();
        hready = 0;
        chk("R4 back to waiting", src_arb_req, 0);
        dst_arb_gnt = 1; bus_gnt = 1;
        #1 chk("R2 dst strobe", dst_xfer_strb, 1);
        tick();
        dst_arb_gnt = 0; bus_gnt = 0; hready = 1;
        tick();
        hready = 0;
        chk("R1 dst released", dst_arb_req, 0);
        idle_all();
    endtask

    task automatic t_fifo_wait();
        ch_en = 1; src_burst_req = 1; src_fifo_rdy = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R6 no req while FIFO not ready", src_arb_req, 0);
        end
        src_fifo_rdy = 1;
        tick();
        chk("R6 req after FIFO ready", src_arb_req, 1);
        src_burst_req = 0;
        src_arb_gnt = 1; bus_gnt = 1;
        tick();
        src_arb_gnt = 0; bus_gnt = 0; hready = 1;
        tick();
        hready = 0;
        idle_all();
    endtask

    task automatic t_memory();
        ch_en = 1; dst_is_mem = 1; dst_fifo_rdy = 0;
        tick(); tick();
        chk("R5 mem side waits FIFO", dst_arb_req, 0);
        dst_fifo_rdy = 1;
        tick();
        chk("R5 mem side requests w/o handshake", dst_arb_req, 1);
        dst_arb_gnt = 1; bus_gnt = 1;
        tick();
        dst_arb_gnt = 0; bus_gnt = 0; hready = 1;
        tick();
        hready = 0;
        idle_all();
    endtask

    task automatic t_retry();
        ch_en = 1; src_is_mem = 1; src_fifo_rdy = 1;
        tick(); tick();
        chk("R5 src mem req", src_arb_req, 1);
        src_arb_gnt = 1; bus_gnt = 1;
        tick();
        src_arb_gnt = 0; bus_gnt = 0; src_fifo_rdy = 0;
        hready = 1; hresp = 2'b10;
        tick();
        hready = 0;
        chk("R8 reissue after RETRY", src_reissue, 1);
        chk("R8 req after RETRY ignoring FIFO", src_arb_req, 1);
        src_arb_gnt = 1; bus_gnt = 1;
        #1 chk("R8 reissue strobe", src_xfer_strb, 1);
        tick();
        src_arb_gnt = 0; bus_gnt = 0;
        hready = 1; hresp = 2'b11;
        tick();
        hready = 0;
        chk("R8 reissue after SPLIT", src_reissue, 1);
        src_arb_gnt = 1; bus_gnt = 1;
        tick();
        src_arb_gnt = 0; bus_gnt = 0;
        hready = 1; hresp = 2'b00;
        tick();
        hready = 0;
        chk("R8 OKAY clears reissue", src_reissue, 0);
        chk("R8 no req after OKAY w/o FIFO", src_arb_req, 0);
        idle_all();
    endtask

    task automatic t_error();
        ch_en = 1; dst_is_mem = 1; dst_fifo_rdy = 1;
        tick(); tick();
        dst_arb_gnt = 1; bus_gnt = 1;
        tick();
        dst_arb_gnt = 0; bus_gnt = 0;
        hready = 1; hresp = 2'b01;
        tick();
        hready = 0; hresp = 2'b00;
        for (int i = 0; i < 3; i++) begin
            chk("R9 err sticky", dst_err, 1);
            chk("R9 no req in error", dst_arb_req, 0);
            tick();
        end
        ch_en = 0;
        tick();
        chk("R9 err cleared by disable", dst_err, 0);
        idle_all();
    endtask

    task automatic t_prefetch();
        ch_en = 1; dst_is_flowctl = 1; prefetch_off = 1;
        src_is_mem = 1; src_fifo_rdy = 1; dst_fifo_rdy = 0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R7 src held off", src_arb_req, 0);
        end
        dst_single_req = 1;
        tick();
        dst_single_req = 0;
        chk("R7 src not yet", src_arb_req, 0);
        tick();
        chk("R7 src req after dst want", src_arb_req, 1);
        src_arb_gnt = 1; bus_gnt = 1;
        tick();
        src_arb_gnt = 0; bus_gnt = 0; hready = 1; hresp = 2'b00;
        tick();
        hready = 0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R7 permission consumed", src_arb_req, 0);
        end
        chk("R7 dst untouched", dst_arb_req, 0);
        idle_all();
    endtask

    initial begin
        #2000000;
        if (!done_flag) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        idle_all();
        tick();
        rst_n = 1;
        tick();
        t_reset();
        t_disabled();
        t_handshake();
        t_fifo_wait();
        t_memory();
        t_retry();
        t_error();
        t_prefetch();
        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule